// File: doc/BRIEF.md
# Bus Width Data Assembly Buffer

This block joins a 32-bit bus master to a slave that may be 8, 16 or 32 bits wide. A master access comes with four byte enables. The block turns it into as many narrow slave cycles as the slave width and the set of active enables require. Lanes with an inactive enable never cause a slave cycle. Cycles are issued from the lowest active lane upward.

On a read, each slave cycle returns its bytes on the low lanes of the slave data bus. The block steers them into the matching lanes of a 32-bit holding latch. After the final narrow cycle, it presents the whole latch to the master with a one-cycle valid strobe. On a write, the master word is captured at acceptance. For each slave cycle, the lanes being written are copied down onto the low lanes of the slave data bus.

After the last slave cycle there is one idle turnaround clock. Then both acknowledge outputs are raised together for one clock to give the cycle back to the master. A DMA-style transfer keeps control to the end and gives no handback pulse. New requests are taken only while the sequencer is idle.

Top module: `width_adapt_buf`

## Requirements
- R1: A synchronous active-high reset empties the holding latch (rdata_o = 0) and forces the idle state: slv_cyc_o, rvalid_o, ack16_o and ack32_o are all low.
- R2: With width code 0 (8-bit slave), a read with all enables active becomes four slave cycles on lanes 0, 1, 2 and 3 in that order. Each cycle has a one-hot slv_be_o, and the returned byte (slave data bits 7:0) is stored in that master lane.
- R3: With width code 0, a write becomes one slave cycle per active lane. slv_wdata_o bits 7:0 carry the master byte of lane slv_lane_o, and slv_we_o is high.
- R4: With width code 1 (16-bit slave), a full-enable access takes two cycles: slv_be_o=0011 with slv_lane_o=0, then slv_be_o=1100 with slv_lane_o=2. The slave half-word travels on data bits 15:0.
- R5: Lanes whose enable is inactive produce no slave cycle. A lane pair with no active enable is skipped entirely, and slv_be_o of a 16-bit cycle shows only the active lanes of its pair.
- R6: Width codes 2 and 3 (32-bit slave) pass the access through in a single slave cycle with slv_lane_o=0, slv_be_o equal to the request enables, and data in place.
- R7: A read updates only the enabled lanes of the holding latch; the other lanes keep their earlier values. rvalid_o is high for exactly the one clock after the final slave-done, and rdata_o holds the assembled word in that clock. A write gives no rvalid_o.
- R8: A slave cycle keeps slv_lane_o, slv_be_o and slv_we_o steady until slv_done_i is seen high at a clock edge.
- R9: After the final slave-done, one clock passes with no slave cycle and no acknowledge. Then ack16_o and ack32_o are both high for exactly one clock, and the block is idle after that.
- R10: A request with dma_i high performs the same slave cycles and turnaround, but never raises ack16_o or ack32_o. It returns to idle straight after the turnaround clock.
- R11: A request is ignored when it is made outside the idle state, including during the handback clock, or when all of its byte enables are zero. It produces no slave cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Master access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| dma_i | input | 1 | Transfer keeps control to the end, no handback |
| be_i | input | LANES (4) | Master byte enables, bit n = lane n |
| width_i | input | 2 | Slave width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| wdata_i | input | DW (32) | Master write word |
| slv_rdata_i | input | DW (32) | Slave read data, slave bytes on the low lanes |
| slv_done_i | input | 1 | Current slave cycle completes at this edge |
| slv_cyc_o | output | 1 | Slave cycle in progress |
| slv_we_o | output | 1 | Slave cycle is a write |
| slv_lane_o | output | 2 | Lowest master lane of the slave's aligned group |
| slv_be_o | output | LANES (4) | Master lanes moved by this slave cycle |
| slv_wdata_o | output | DW (32) | Write data copied down to the slave's low lanes |
| rdata_o | output | DW (32) | Holding latch contents |
| rvalid_o | output | 1 | Assembled read word valid |
| ack16_o | output | 1 | Handback strobe, 16-bit acknowledge |
| ack32_o | output | 1 | Handback strobe, 32-bit acknowledge |

## Verification
The handback clock and a new master request can arrive in the same cycle. A master that retries at once will hit that window, and the block must not start a second sequence there. The bench waits for the acknowledge pulse and drives a full-enable request in that very clock. It then requires that no slave cycle appears in the clocks that follow. A second overlap is the final slave-done against the read-valid strobe. The scoreboard requires the assembled word exactly one clock after that done, and no slave cycle in that same clock.

// File: rtl/wab_pkg.sv
package wab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TURN = 2'd2,
        ST_HAND = 2'd3
    } seq_state_e;

    // slave width codes; code 3 is treated as a full-width slave
    typedef enum logic [1:0] {
        SW_NARROW8  = 2'd0,
        SW_NARROW16 = 2'd1,
        SW_FULL     = 2'd2,
        SW_FULL_ALT = 2'd3
    } slv_width_e;

endpackage

// File: rtl/wab_chunk_plan.sv
module wab_chunk_plan #(
    parameter int LANES = 4,
    parameter int IDXW  = 2
) (
    input  logic [LANES-1:0] rem_i,
    input  logic [1:0]       wcode_i,
    output logic [IDXW-1:0]  base_o,
    output logic [LANES-1:0] mask_o,
    output logic             last_o
);
    int              span_w;
    logic [IDXW-1:0] lo_w;

    always_comb begin
        // lanes the slave covers in one cycle, capped by the master width
        span_w = 1 << wcode_i;
        if (span_w > LANES) begin
            span_w = LANES;
        end
        // lowest remaining lane wins
        lo_w = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (rem_i[i]) begin
                lo_w = IDXW'(i);
            end
        end
        // align down to the slave group that holds that lane
        base_o = lo_w & ~IDXW'(span_w - 1);
        for (int i = 0; i < LANES; i++) begin
            mask_o[i] = rem_i[i] && (i >= int'(base_o)) && (i < int'(base_o) + span_w);
        end
        last_o = (rem_i & ~mask_o) == '0;
    end

endmodule

// File: rtl/wab_rd_steer.sv
module wab_rd_steer #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int IDXW   = 2
) (
    input  logic [LANES*LANE_W-1:0] hold_i,
    input  logic [LANES*LANE_W-1:0] slv_rdata_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [IDXW-1:0]         base_i,
    input  logic                    capture_i,
    output logic [LANES*LANE_W-1:0] hold_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDXW-1:0] src;
        // slave byte index that feeds master lane g
        assign src = IDXW'(g) - base_i;
        assign hold_o[g*LANE_W +: LANE_W] = (capture_i && mask_i[g])
                                          ? slv_rdata_i[src*LANE_W +: LANE_W]
                                          : hold_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/wab_wr_steer.sv
module wab_wr_steer #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int IDXW   = 2
) (
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [IDXW-1:0]         base_i,
    output logic [LANES*LANE_W-1:0] wdata_o
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDXW:0] src;
        // slave lane j carries master lane j + base
        assign src = (IDXW+1)'(j) + {1'b0, base_i};
        assign wdata_o[j*LANE_W +: LANE_W] = (src < (IDXW+1)'(LANES))
                                           ? wdata_i[src[IDXW-1:0]*LANE_W +: LANE_W]
                                           : '0;
    end

endmodule

// File: rtl/width_adapt_buf.sv
module width_adapt_buf #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                req_i,
    input  logic                                we_i,
    input  logic                                dma_i,
    input  logic [LANES-1:0]                    be_i,
    input  logic [1:0]                          width_i,
    input  logic [LANES*LANE_W-1:0]             wdata_i,
    input  logic [LANES*LANE_W-1:0]             slv_rdata_i,
    input  logic                                slv_done_i,
    output logic                                slv_cyc_o,
    output logic                                slv_we_o,
    output logic [(LANES>1?$clog2(LANES):1)-1:0] slv_lane_o,
    output logic [LANES-1:0]                    slv_be_o,
    output logic [LANES*LANE_W-1:0]             slv_wdata_o,
    output logic [LANES*LANE_W-1:0]             rdata_o,
    output logic                                rvalid_o,
    output logic                                ack16_o,
    output logic                                ack32_o
);
    import wab_pkg::*;

    localparam int DW   = LANES * LANE_W;
    localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [LANES-1:0] rem;
        logic [1:0]       wcode;
        logic             we;
        logic             dma;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    hold;
        logic             rvalid;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDXW-1:0]  base_w;
    logic [LANES-1:0] mask_w;
    logic             last_w;
    logic             in_xfer_w;
    logic             capture_w;
    logic [DW-1:0]    hold_nx_w;
    logic [DW-1:0]    wsteer_w;

    assign in_xfer_w = (r_q.st == ST_XFER);
    assign capture_w = in_xfer_w && slv_done_i && !r_q.we;

    wab_chunk_plan #(.LANES(LANES), .IDXW(IDXW)) plan_i (
        .rem_i   (r_q.rem),
        .wcode_i (r_q.wcode),
        .base_o  (base_w),
        .mask_o  (mask_w),
        .last_o  (last_w)
    );

    wab_rd_steer #(.LANES(LANES), .LANE_W(LANE_W), .IDXW(IDXW)) rd_i (
        .hold_i      (r_q.hold),
        .slv_rdata_i (slv_rdata_i),
        .mask_i      (mask_w),
        .base_i      (base_w),
        .capture_i   (capture_w),
        .hold_o      (hold_nx_w)
    );

    wab_wr_steer #(.LANES(LANES), .LANE_W(LANE_W), .IDXW(IDXW)) wr_i (
        .wdata_i (r_q.wdata),
        .base_i  (base_w),
        .wdata_o (wsteer_w)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.hold   = hold_nx_w;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i && (be_i != '0)) begin
                    r_d.st    = ST_XFER;
                    r_d.rem   = be_i;
                    r_d.wcode = width_i;
                    r_d.we    = we_i;
                    r_d.dma   = dma_i;
                    r_d.wdata = wdata_i;
                end
            end
            ST_XFER: begin
                if (slv_done_i) begin
                    r_d.rem = r_q.rem & ~mask_w;
                    if (last_w) begin
                        r_d.st     = ST_TURN;
                        r_d.rvalid = !r_q.we;
                    end
                end
            end
            ST_TURN: begin
                r_d.st = r_q.dma ? ST_IDLE : ST_HAND;
            end
            ST_HAND: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign slv_cyc_o   = in_xfer_w;
    assign slv_we_o    = in_xfer_w && r_q.we;
    assign slv_lane_o  = base_w;
    assign slv_be_o    = in_xfer_w ? mask_w : '0;
    assign slv_wdata_o = (in_xfer_w && r_q.we) ? wsteer_w : '0;
    assign rdata_o     = r_q.hold;
    assign rvalid_o    = r_q.rvalid;
    assign ack16_o     = (r_q.st == ST_HAND);
    assign ack32_o     = (r_q.st == ST_HAND);

endmodule

module wab_chk #(
    parameter int LANES = 4,
    parameter int IDXW  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             slv_cyc_o,
    input logic             slv_done_i,
    input logic [IDXW-1:0]  slv_lane_o,
    input logic [LANES-1:0] slv_be_o,
    input logic             slv_we_o,
    input logic             rvalid_o,
    input logic             ack16_o,
    input logic             ack32_o
);
    // R9
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ack16_o || ack32_o) |-> !$past(slv_cyc_o));

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack32_o |=> !ack32_o && !ack16_o);

    // R8
    chunk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (slv_cyc_o && !slv_done_i) |=> slv_cyc_o && $stable(slv_be_o)
                                        && $stable(slv_lane_o) && $stable(slv_we_o));

    // R5
    chunk_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        slv_cyc_o |-> (slv_be_o != '0));

    // R4
    lane_floor_chk: assert property (@(posedge clk) disable iff (rst)
        slv_cyc_o |-> (LANES'(LANES'(slv_be_o >> slv_lane_o) << slv_lane_o) == slv_be_o));

    // R7
    rvalid_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> ($past(slv_cyc_o && slv_done_i) && !slv_cyc_o));

endmodule

bind width_adapt_buf wab_chk #(.LANES(LANES), .IDXW(IDXW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .slv_cyc_o  (slv_cyc_o),
    .slv_done_i (slv_done_i),
    .slv_lane_o (slv_lane_o),
    .slv_be_o   (slv_be_o),
    .slv_we_o   (slv_we_o),
    .rvalid_o   (rvalid_o),
    .ack16_o    (ack16_o),
    .ack32_o    (ack32_o)
);

// File: tb/width_adapt_buf_tb_top.sv
module width_adapt_buf_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0, we_i = 1'b0, dma_i = 1'b0;
    logic [3:0]  be_i = '0;
    logic [1:0]  width_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] slv_rdata_i;
    logic        slv_done_i = 1'b0;
    logic        slv_cyc_o, slv_we_o, rvalid_o, ack16_o, ack32_o;
    logic [1:0]  slv_lane_o;
    logic [3:0]  slv_be_o;
    logic [31:0] slv_wdata_o, rdata_o;

    typedef struct {
        logic [1:0]  lane;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] wm;
        logic        we;
        logic        dma;
        logic        last;
        string       tag;
    } chunk_t;

    chunk_t      exp_q[$];
    logic [31:0] res_q[$];
    string       res_tag_q[$];
    int          n_chk = 0, n_fail = 0;
    int          ph = 0;
    logic        ph_dma = 1'b0;
    int          wait_n = 0;
    int          wcnt = 0;
    logic [31:0] slv_mem = 32'h0;
    logic [31:0] model_hold = 32'h0;
    bit          done_flag = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    width_adapt_buf dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .dma_i(dma_i),
        .be_i(be_i), .width_i(width_i), .wdata_i(wdata_i),
        .slv_rdata_i(slv_rdata_i), .slv_done_i(slv_done_i),
        .slv_cyc_o(slv_cyc_o), .slv_we_o(slv_we_o), .slv_lane_o(slv_lane_o),
        .slv_be_o(slv_be_o), .slv_wdata_o(slv_wdata_o), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .ack16_o(ack16_o), .ack32_o(ack32_o)
    );

    // slave model: presents the bytes of its addressed group on the low lanes
    assign slv_rdata_i = (slv_mem >> (int'(slv_lane_o) * 8))
                       | (slv_mem << (32 - int'(slv_lane_o) * 8));

    always @(negedge clk) begin
        if (rst) begin
            slv_done_i <= 1'b0;
            wcnt       <= 0;
        end else if (slv_done_i) begin
            slv_done_i <= 1'b0;
            wcnt       <= 0;
        end else if (slv_cyc_o) begin
            if (wcnt >= wait_n) slv_done_i <= 1'b1;
            else                wcnt       <= wcnt + 1;
        end
    end

    function automatic logic [31:0] bmask(input logic [3:0] b);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{b[i]}};
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares every sample against the front of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (ph == 1) begin
                    chk(!slv_cyc_o && !ack16_o && !ack32_o, "R9 turnaround clock",
                        {29'd0, slv_cyc_o, ack16_o, ack32_o}, 32'd0);
                    ph = 2;
                end else if (ph == 2) begin
                    chk(ack16_o == !ph_dma && ack32_o == !ph_dma,
                        ph_dma ? "R10 no handback" : "R9 handback both acks",
                        {30'd0, ack16_o, ack32_o}, ph_dma ? 32'd0 : 32'd3);
                    ph = ph_dma ? 0 : 3;
                end else if (ph == 3) begin
                    chk(!ack16_o && !ack32_o && !slv_cyc_o, "R9 handback single clock",
                        {29'd0, slv_cyc_o, ack16_o, ack32_o}, 32'd0);
                    ph = 0;
                end else if (ack16_o || ack32_o) begin
                    chk(1'b0, "R9 unexpected handback", {30'd0, ack16_o, ack32_o}, 32'd0);
                end

                if (slv_cyc_o) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R11 unexpected slave cycle", {28'd0, slv_be_o}, 32'd0);
                    end else begin
                        chunk_t c;
                        c = exp_q[0];
                        chk(slv_lane_o == c.lane && slv_be_o == c.be && slv_we_o == c.we,
                            {c.tag, " lane/be/we"},
                            {25'd0, slv_we_o, slv_lane_o, slv_be_o},
                            {25'd0, c.we, c.lane, c.be});
                        if (c.we)
                            chk((slv_wdata_o & c.wm) == (c.wd & c.wm), {c.tag, " write data"},
                                slv_wdata_o & c.wm, c.wd & c.wm);
                        if (slv_done_i) begin
                            void'(exp_q.pop_front());
                            if (c.last) begin
                                ph     = 1;
                                ph_dma = c.dma;
                            end
                        end
                    end
                end

                if (rvalid_o) begin
                    if (res_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected rvalid", rdata_o, 32'd0);
                    end else begin
                        logic [31:0] e;
                        string       t;
                        e = res_q.pop_front();
                        t = res_tag_q.pop_front();
                        chk(rdata_o == e, t, rdata_o, e);
                    end
                end
            end
        end
    end

    // driver: pushes the expected slave cycles, then issues the request
    task automatic run_txn(input logic we, input logic dma, input logic [3:0] be,
                           input logic [1:0] w, input logic [31:0] wd,
                           input logic [31:0] mem, input int wt,
                           input bit poke_busy, input bit poke_hand, input string tag);
        int span;
        span    = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
        wait_n  = wt;
        slv_mem = mem;
        for (int g = 0; g < 4; g += span) begin
            logic [3:0] grp;
            grp = 4'(((1 << span) - 1) << g);
            if ((be & grp) != 4'd0) begin
                chunk_t c;
                c.lane = 2'(g);
                c.be   = be & grp;
                c.wd   = wd >> (g * 8);
                c.wm   = bmask(4'((be & grp) >> g));
                c.we   = we;
                c.dma  = dma;
                c.last = 1'b0;
                c.tag  = tag;
                exp_q.push_back(c);
            end
        end
        exp_q[exp_q.size()-1].last = 1'b1;
        if (!we) begin
            model_hold = (model_hold & ~bmask(be)) | (mem & bmask(be));
            res_q.push_back(model_hold);
            res_tag_q.push_back({tag, " assembled word"});
        end
        @(negedge clk);
        req_i = 1'b1; we_i = we; dma_i = dma; be_i = be; width_i = w; wdata_i = wd;
        @(negedge clk);
        req_i = 1'b0;
        if (poke_busy) begin
            // R11: requests while a transfer is running must be dropped
            req_i = 1'b1; be_i = 4'hF; width_i = 2'd0; we_i = 1'b1;
            repeat (3) @(negedge clk);
            req_i = 1'b0;
        end
        if (poke_hand) begin
            wait (ack16_o);
            @(negedge clk);
            req_i = 1'b1; be_i = 4'hF; width_i = 2'd0; we_i = 1'b0; dma_i = 1'b0;
            @(negedge clk);
            req_i = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                #2;
                chk(!slv_cyc_o, "R11 request in handback clock ignored",
                    {31'd0, slv_cyc_o}, 32'd0);
            end
        end
        while (exp_q.size() != 0 || ph != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1
        chk(!slv_cyc_o && !rvalid_o && !ack16_o && !ack32_o && rdata_o == 32'd0,
            "R1 reset state", rdata_o, 32'd0);

        run_txn(1'b0, 1'b0, 4'hF, 2'd0, 32'h0, 32'hD4C3B2A1, 0, 0, 0, "R2 8-bit full read");
        run_txn(1'b1, 1'b0, 4'hF, 2'd0, 32'h44332211, 32'h0, 1, 0, 0, "R3 8-bit full write");
        run_txn(1'b0, 1'b0, 4'hF, 2'd1, 32'h0, 32'h87654321, 2, 0, 0, "R4 16-bit full read");
        run_txn(1'b1, 1'b0, 4'hF, 2'd1, 32'hCAFEF00D, 32'h0, 0, 0, 0, "R4 16-bit full write");
        run_txn(1'b0, 1'b0, 4'b1010, 2'd0, 32'h0, 32'h5A6B7C8D, 0, 0, 0, "R5 8-bit sparse read");
        run_txn(1'b0, 1'b0, 4'b0110, 2'd1, 32'h0, 32'h13579BDF, 1, 0, 0, "R5 16-bit split pair read");
        run_txn(1'b1, 1'b0, 4'b0100, 2'd0, 32'hA1B2C3D4, 32'h0, 0, 0, 0, "R5 8-bit single lane write");
        run_txn(1'b1, 1'b0, 4'b1100, 2'd1, 32'hBEEF0000, 32'h0, 0, 0, 0, "R5 16-bit high pair write");
        run_txn(1'b0, 1'b0, 4'hF, 2'd2, 32'h0, 32'h0BADF00D, 0, 0, 0, "R6 32-bit read");
        run_txn(1'b1, 1'b0, 4'b1011, 2'd3, 32'h76543210, 32'h0, 1, 0, 0, "R6 code3 write");
        run_txn(1'b0, 1'b0, 4'b0001, 2'd0, 32'h0, 32'hFFFFFF99, 0, 0, 0, "R7 partial read keeps lanes");
        run_txn(1'b0, 1'b0, 4'b1000, 2'd1, 32'h0, 32'h11EE22DD, 0, 0, 0, "R7 high-byte 16-bit read");
        run_txn(1'b0, 1'b1, 4'b0011, 2'd0, 32'h0, 32'h00002468, 0, 0, 0, "R10 dma read");
        run_txn(1'b1, 1'b1, 4'hF, 2'd1, 32'h89ABCDEF, 32'h0, 0, 0, 0, "R10 dma write");
        run_txn(1'b0, 1'b0, 4'b0101, 2'd0, 32'h0, 32'h31415926, 4, 1, 0, "R8 R11 long waits with busy requests");
        run_txn(1'b0, 1'b0, 4'hF, 2'd0, 32'h0, 32'h27182818, 0, 0, 1, "R11 handback overlap");

        // R11: zero enables never start a transfer
        @(negedge clk);
        req_i = 1'b1; be_i = 4'h0; width_i = 2'd0; we_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #2;
            chk(!slv_cyc_o && !ack16_o, "R11 zero enables ignored",
                {30'd0, slv_cyc_o, ack16_o}, 32'd0);
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule